// File: doc/BRIEF.md
# Temporal Operand Belt

This block is a fixed-length operand queue that takes the place of a register file. Results are not written to a named location. Each cycle, up to `DROPS` issue slots can drop a result onto the front of the belt. Every entry already on the belt moves back by the number of new results. An entry pushed beyond the last position is gone. Consumers name an operand by its age: position 0 holds the newest value, and position k holds the k-th newest. Comparison outcomes and other flags are ordinary entries too. There is no hidden state beside the belt.

An entry can be dropped as a placeholder for a result that has not arrived yet, such as a memory load. A placeholder carries a fill identifier. When the data returns with that identifier, it is written into whichever position the placeholder has reached by then. A read port that names a placeholder raises a stall, and only that port stalls. Reads are combinational from the registered belt, so a value dropped in one cycle can be read from the next cycle.

Each belt position is a small state machine with three states:
- `SLOT_EMPTY` holds nothing.
- `SLOT_PENDING` is a placeholder that waits for its fill.
- `SLOT_READY` holds a final value.

The transitions are:
- *drop-ready*: a value arrives from an issue slot in `SLOT_READY`.
- *drop-pending*: a placeholder arrives from an issue slot in `SLOT_PENDING`.
- *fill*: `SLOT_PENDING` becomes `SLOT_READY` when the data returns.
- *shift*: the state moves one or more positions back together with the entry.
- *fall-off*: the entry leaves the last position and is discarded.
- *clear*: a synchronous reset returns every position to `SLOT_EMPTY`.

Top module: `belt_store`

## Requirements
- R1: A synchronous reset empties the belt. Occupancy then reads 0 and every read port flags an error.
- R2: A single dropped result appears at position 0 from the cycle after the drop, and occupancy grows by one.
- R3: When several slots drop in one cycle, the enabled slots take positions 0, 1, … in increasing slot-index order. Older entries shift back by the number of drops in that same cycle.
- R4: In a cycle with no drops, every entry keeps its position and value (write-once).
- R5: Occupancy saturates at `LENGTH`. An entry pushed past position `LENGTH-1` is discarded with no signal.
- R6: A read at a position equal to or greater than occupancy raises that port's error flag and does not raise stall.
- R7: A read of a placeholder entry raises that port's stall flag. A read of a ready entry does not.
- R8: A fill whose identifier matches a placeholder writes its data into that entry's current position and marks it ready. This holds even if drops shift the entry in the same cycle. The stall clears from the next cycle.
- R9: A fill whose identifier matches no placeholder changes nothing on the belt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drop_en | input | DROPS | Per issue slot: drop a result this cycle |
| drop_pend | input | DROPS | Per issue slot: the drop is a placeholder awaiting a fill |
| drop_data | input | DROPS*DATA_W | Per issue slot: the result value (slot s at bits s*DATA_W) |
| drop_tag | input | DROPS*TAG_W | Per issue slot: the fill identifier of a placeholder |
| fill_en | input | 1 | Returning data is valid |
| fill_tag | input | TAG_W | Identifier of the returning data |
| fill_data | input | DATA_W | Returning data value |
| rd_pos | input | READS*POS_W | Per read port: position counted back from the newest |
| rd_data | output | READS*DATA_W | Per read port: operand value, zero when stalled or in error |
| rd_stall | output | READS | Per read port: the named entry is a placeholder |
| rd_err | output | READS | Per read port: the named position holds no entry |
| occupancy | output | CNT_W | Number of entries on the belt |

## Verification
The assertions assume the following about the inputs:
- At any time, at most one placeholder on the belt carries a given fill identifier. A fill therefore hits a single position.
- Read positions are below `LENGTH`.

The stimulus keeps within these limits. It gives each outstanding placeholder its own identifier (3 and 7). It sends one fill with identifier 5, which no placeholder uses. It picks read positions only inside the configured belt of eight entries. The shift and hold properties assume that a ready entry is never the target of a fill. The fill property checks only cycles with no drops. Fills that coincide with drops are covered by a directed test.

// File: rtl/belt_pkg.sv
package belt_pkg;

    // State of one belt position
    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_PENDING = 2'd1,
        SLOT_READY   = 2'd2
    } slot_state_e;

endpackage

// File: rtl/belt_drop_pack.sv
// Packs the enabled issue slots, in slot-index order, into front positions.
module belt_drop_pack
    import belt_pkg::*;
#(
    parameter int DROPS  = 2,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int DCNT_W = $clog2(DROPS + 1)
) (
    input  logic [DROPS-1:0]        drop_en,
    input  logic [DROPS-1:0]        drop_pend,
    input  logic [DROPS*DATA_W-1:0] drop_data,
    input  logic [DROPS*TAG_W-1:0]  drop_tag,
    output slot_state_e             new_st   [DROPS],
    output logic [DATA_W-1:0]       new_data [DROPS],
    output logic [TAG_W-1:0]        new_tag  [DROPS],
    output logic [DCNT_W-1:0]       drop_cnt
);

    always_comb begin
        int k;
        k = 0;
        for (int j = 0; j < DROPS; j++) begin
            new_st[j]   = SLOT_EMPTY;
            new_data[j] = '0;
            new_tag[j]  = '0;
        end
        for (int s = 0; s < DROPS; s++) begin
            if (drop_en[s]) begin
                for (int j = 0; j < DROPS; j++) begin
                    if (j == k) begin
                        new_st[j]   = drop_pend[s] ? SLOT_PENDING : SLOT_READY;
                        new_data[j] = drop_pend[s] ? '0 : drop_data[s*DATA_W +: DATA_W];
                        new_tag[j]  = drop_tag[s*TAG_W +: TAG_W];
                    end
                end
                k = k + 1;
            end
        end
        drop_cnt = DCNT_W'(k);
    end

endmodule

// File: rtl/belt_read_port.sv
// One read port: selects the entry at a relative position from the registered belt.
module belt_read_port
    import belt_pkg::*;
#(
    parameter int LENGTH = 64,
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(LENGTH),
    localparam int CNT_W = $clog2(LENGTH + 1)
) (
    input  slot_state_e       st   [LENGTH],
    input  logic [DATA_W-1:0] data [LENGTH],
    input  logic [CNT_W-1:0]  count,
    input  logic [POS_W-1:0]  pos,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_stall,
    output logic              rd_err
);

    always_comb begin
        rd_err   = (CNT_W'(pos) >= count);
        rd_stall = !rd_err && (st[pos] == SLOT_PENDING);
        rd_data  = (rd_err || rd_stall) ? '0 : data[pos];
    end

endmodule

// File: rtl/belt_store.sv
module belt_store
    import belt_pkg::*;
#(
    parameter int LENGTH = 64,
    parameter int DROPS  = 2,
    parameter int READS  = 2,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int POS_W  = $clog2(LENGTH),
    localparam int CNT_W  = $clog2(LENGTH + 1),
    localparam int DCNT_W = $clog2(DROPS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DROPS-1:0]        drop_en,
    input  logic [DROPS-1:0]        drop_pend,
    input  logic [DROPS*DATA_W-1:0] drop_data,
    input  logic [DROPS*TAG_W-1:0]  drop_tag,
    input  logic                    fill_en,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [DATA_W-1:0]       fill_data,
    input  logic [READS*POS_W-1:0]  rd_pos,
    output logic [READS*DATA_W-1:0] rd_data,
    output logic [READS-1:0]        rd_stall,
    output logic [READS-1:0]        rd_err,
    output logic [CNT_W-1:0]        occupancy
);

    // Registered belt
    slot_state_e       st_q   [LENGTH];
    logic [DATA_W-1:0] data_q [LENGTH];
    logic [TAG_W-1:0]  tag_q  [LENGTH];
    logic [CNT_W-1:0]  cnt_q;

    // Next belt
    slot_state_e       st_d   [LENGTH];
    logic [DATA_W-1:0] data_d [LENGTH];
    logic [TAG_W-1:0]  tag_d  [LENGTH];
    logic [CNT_W-1:0]  cnt_d;

    // Entries after the fill, before the shift
    slot_state_e       af_st   [LENGTH];
    logic [DATA_W-1:0] af_data [LENGTH];
    logic [LENGTH-1:0] fill_hit;

    // Packed new results
    slot_state_e       new_st   [DROPS];
    logic [DATA_W-1:0] new_data [DROPS];
    logic [TAG_W-1:0]  new_tag  [DROPS];
    logic [DCNT_W-1:0] drop_cnt;

    belt_drop_pack #(
        .DROPS  (DROPS),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_pack (
        .drop_en   (drop_en),
        .drop_pend (drop_pend),
        .drop_data (drop_data),
        .drop_tag  (drop_tag),
        .new_st    (new_st),
        .new_data  (new_data),
        .new_tag   (new_tag),
        .drop_cnt  (drop_cnt)
    );

    // Per-position fill and shift selection
    for (genvar i = 0; i < LENGTH; i++) begin : g_ent
        slot_state_e       cand_st   [DROPS+1];
        logic [DATA_W-1:0] cand_data [DROPS+1];
        logic [TAG_W-1:0]  cand_tag  [DROPS+1];

        assign fill_hit[i] = fill_en && (st_q[i] == SLOT_PENDING) && (tag_q[i] == fill_tag);
        assign af_st[i]    = fill_hit[i] ? SLOT_READY : st_q[i];
        assign af_data[i]  = fill_hit[i] ? fill_data : data_q[i];

        for (genvar p = 0; p <= DROPS; p++) begin : g_cand
            if (i < p) begin : g_new
                assign cand_st[p]   = new_st[i];
                assign cand_data[p] = new_data[i];
                assign cand_tag[p]  = new_tag[i];
            end else begin : g_old
                assign cand_st[p]   = af_st[i-p];
                assign cand_data[p] = af_data[i-p];
                assign cand_tag[p]  = tag_q[i-p];
            end
        end

        assign st_d[i]   = cand_st[drop_cnt];
        assign data_d[i] = cand_data[drop_cnt];
        assign tag_d[i]  = cand_tag[drop_cnt];

        // R4: a ready entry stays put when nothing is dropped
        AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
            (drop_cnt == '0 && st_q[i] == SLOT_READY) |=>
            (st_q[i] == SLOT_READY && data_q[i] == $past(data_q[i]))); // R4

        if (i < LENGTH - 1) begin : g_shift_chk
            AST_SHIFT_ONE: assert property (@(posedge clk) disable iff (rst)
                (drop_cnt == DCNT_W'(1) && st_q[i] == SLOT_READY) |=>
                (data_q[i+1] == $past(data_q[i]))); // R3
        end

        AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (drop_cnt == '0 && fill_hit[i]) |=>
            (st_q[i] == SLOT_READY && data_q[i] == $past(fill_data))); // R8
    end

    // Occupancy, saturating at LENGTH
    always_comb begin
        logic [CNT_W:0] sum;
        sum = {1'b0, cnt_q} + (CNT_W+1)'(drop_cnt);
        cnt_d = (sum > (CNT_W+1)'(LENGTH)) ? CNT_W'(LENGTH) : sum[CNT_W-1:0];
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < LENGTH; i++) begin
                st_q[i]   <= SLOT_EMPTY;
                data_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < LENGTH; i++) begin
                st_q[i]   <= st_d[i];
                data_q[i] <= data_d[i];
                tag_q[i]  <= tag_d[i];
            end
        end
    end

    assign occupancy = cnt_q;

    // Read ports
    for (genvar r = 0; r < READS; r++) begin : g_rd
        belt_read_port #(
            .LENGTH (LENGTH),
            .DATA_W (DATA_W)
        ) u_rd (
            .st       (st_q),
            .data     (data_q),
            .count    (cnt_q),
            .pos      (rd_pos[r*POS_W +: POS_W]),
            .rd_data  (rd_data[r*DATA_W +: DATA_W]),
            .rd_stall (rd_stall[r]),
            .rd_err   (rd_err[r])
        );
    end

    AST_OCC_GROW: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt != '0 && cnt_q < CNT_W'(LENGTH)) |=> (cnt_q > $past(cnt_q))); // R5

    AST_FILL_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> ($countones(fill_hit) <= 1)); // R8

endmodule

// File: tb/tb_belt_store.sv
module tb_belt_store;

    localparam int L  = 8;
    localparam int DW = 16;
    localparam int TW = 4;

    typedef struct packed {
        logic [1:0]  en;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [2:0]  p0;
        logic [2:0]  p1;
        logic [15:0] e0;
        logic [15:0] e1;
        logic [1:0]  err;
        logic [3:0]  occ;
    } vec_t;

    // en, d0, d1, p0, p1, exp0, exp1, err{p1,p0}, occupancy
    localparam vec_t VECS [7] = '{
        '{2'b01, 16'hA001, 16'h0000, 3'd0, 3'd1, 16'hA001, 16'h0000, 2'b10, 4'd1}, // R2
        '{2'b11, 16'hB000, 16'hB001, 3'd0, 3'd2, 16'hB000, 16'hA001, 2'b00, 4'd3}, // R3
        '{2'b10, 16'h0000, 16'hC001, 3'd0, 3'd3, 16'hC001, 16'hA001, 2'b00, 4'd4}, // R3
        '{2'b00, 16'h0000, 16'h0000, 3'd1, 3'd2, 16'hB000, 16'hB001, 2'b00, 4'd4}, // R4
        '{2'b11, 16'hD000, 16'hD001, 3'd5, 3'd6, 16'hA001, 16'h0000, 2'b10, 4'd6}, // R6
        '{2'b11, 16'hE000, 16'hE001, 3'd7, 3'd0, 16'hA001, 16'hE000, 2'b00, 4'd8}, // R5
        '{2'b01, 16'hF000, 16'h0000, 3'd7, 3'd1, 16'hB001, 16'hE000, 2'b00, 4'd8}  // R5
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      drop_en = '0;
    logic [1:0]      drop_pend = '0;
    logic [2*DW-1:0] drop_data = '0;
    logic [2*TW-1:0] drop_tag = '0;
    logic            fill_en = 1'b0;
    logic [TW-1:0]   fill_tag = '0;
    logic [DW-1:0]   fill_data = '0;
    logic [5:0]      rd_pos = '0;
    logic [2*DW-1:0] rd_data;
    logic [1:0]      rd_stall;
    logic [1:0]      rd_err;
    logic [3:0]      occupancy;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    belt_store #(
        .LENGTH (L),
        .DROPS  (2),
        .READS  (2),
        .DATA_W (DW),
        .TAG_W  (TW)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .drop_en   (drop_en),
        .drop_pend (drop_pend),
        .drop_data (drop_data),
        .drop_tag  (drop_tag),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .rd_pos    (rd_pos),
        .rd_data   (rd_data),
        .rd_stall  (rd_stall),
        .rd_err    (rd_err),
        .occupancy (occupancy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then idle the write side after the edge
    task automatic step(input logic [1:0] en, input logic [1:0] pend,
                        input logic [15:0] d0, input logic [15:0] d1,
                        input logic [3:0] t0, input logic [3:0] t1,
                        input logic fen, input logic [3:0] ftag, input logic [15:0] fdat,
                        input logic [2:0] p0, input logic [2:0] p1);
        @(negedge clk);
        drop_en   = en;
        drop_pend = pend;
        drop_data = {d1, d0};
        drop_tag  = {t1, t0};
        fill_en   = fen;
        fill_tag  = ftag;
        fill_data = fdat;
        rd_pos    = {p1, p0};
        @(posedge clk);
        #1;
        drop_en = '0;
        drop_pend = '0;
        fill_en = 1'b0;
    endtask

    function automatic string row_req(input int k);
        case (k)
            0: return "R2";
            1, 2: return "R3";
            3: return "R4";
            4: return "R6";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk("R1 occupancy", {28'b0, occupancy}, 32'd0);
        chk("R1 error", {30'b0, rd_err}, 32'd3);

        for (int k = 0; k < 7; k++) begin
            vec_t v;
            v = VECS[k];
            step(v.en, 2'b00, v.d0, v.d1, 4'd0, 4'd0, 1'b0, 4'd0, 16'd0, v.p0, v.p1);
            chk(row_req(k), {28'b0, occupancy}, {28'b0, v.occ});
            chk(row_req(k), {30'b0, rd_stall}, 32'd0);
            chk(row_req(k), {31'b0, rd_err[0]}, {31'b0, v.err[0]});
            if (!v.err[0]) chk(row_req(k), {16'b0, rd_data[15:0]}, {16'b0, v.e0});
            chk(row_req(k), {31'b0, rd_err[1]}, {31'b0, v.err[1]});
            if (!v.err[1]) chk(row_req(k), {16'b0, rd_data[31:16]}, {16'b0, v.e1});
        end

        // R1: reset in mid-run empties a full belt
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_pos = {3'd7, 3'd0};
        chk("R1 occupancy after reset", {28'b0, occupancy}, 32'd0);
        chk("R1 error after reset", {30'b0, rd_err}, 32'd3);

        // R7: a placeholder at position 0 stalls its reader
        step(2'b01, 2'b01, 16'h0, 16'h0, 4'd3, 4'd0, 1'b0, 4'd0, 16'd0, 3'd0, 3'd0);
        chk("R7 stall on placeholder", {30'b0, rd_stall}, 32'd3);
        chk("R7 no error on placeholder", {30'b0, rd_err}, 32'd0);

        // R7: only the port that names the placeholder stalls
        step(2'b01, 2'b00, 16'h1111, 16'h0, 4'd0, 4'd0, 1'b0, 4'd0, 16'd0, 3'd0, 3'd1);
        chk("R7 stall per port", {30'b0, rd_stall}, 32'd2);
        chk("R7 ready read", {16'b0, rd_data[15:0]}, 32'h1111);

        // R9: an unmatched fill changes nothing
        step(2'b00, 2'b00, 16'h0, 16'h0, 4'd0, 4'd0, 1'b1, 4'd5, 16'hDEAD, 3'd0, 3'd1);
        chk("R9 stall kept", {30'b0, rd_stall}, 32'd2);
        chk("R9 value kept", {16'b0, rd_data[15:0]}, 32'h1111);
        chk("R9 occupancy kept", {28'b0, occupancy}, 32'd2);

        // R8: fill lands at the shifted position when a drop happens in the same cycle
        step(2'b10, 2'b00, 16'h0, 16'h2222, 4'd0, 4'd0, 1'b1, 4'd3, 16'h3333, 3'd2, 3'd0);
        chk("R8 stall cleared", {30'b0, rd_stall}, 32'd0);
        chk("R8 filled value", {16'b0, rd_data[15:0]}, 32'h3333);
        chk("R8 new head", {16'b0, rd_data[31:16]}, 32'h2222);

        // R8: fill with no drop
        step(2'b01, 2'b01, 16'h0, 16'h0, 4'd7, 4'd0, 1'b0, 4'd0, 16'd0, 3'd0, 3'd3);
        chk("R8 placeholder stalls", {31'b0, rd_stall[0]}, 32'd1);
        step(2'b00, 2'b00, 16'h0, 16'h0, 4'd0, 4'd0, 1'b1, 4'd7, 16'h7777, 3'd0, 3'd3);
        chk("R8 fill clears stall", {30'b0, rd_stall}, 32'd0);
        chk("R8 fill value", {16'b0, rd_data[15:0]}, 32'h7777);
        chk("R8 older value intact", {16'b0, rd_data[31:16]}, 32'h3333);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule